// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This core drives a multichannel sampling converter from a free-running external conversion clock. A rising edge on the start input launches a sequence over the channels picked by a four-bit mask. The selected channels are converted one after another in ascending index order. Each channel occupies a slot of exactly sixteen conversion-clock falling edges, and the status outputs change at fixed edge counts inside that slot. A stub outside the core supplies the 14-bit result for every channel. The core copies that result into a per-channel data register when the channel's slot ends.

The conversion clock is asynchronous to the system clock. It passes through a two-flop synchronizer, and its falling edges are detected in the system domain. After a sequence is accepted, a guard window of a parameterized number of system cycles masks out early falling edges. A host reads results through a read strobe. Each strobe returns the register under the read pointer and moves the pointer to the next selected channel. The pointer rewinds to the lowest selected channel partway through the first slot of each sequence. A low level on the standby input halts conversion activity, and the read path keeps working.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy_o is 0, eoc_no is 1, first_o is 0 and data_o is 0.
- R2: A sequence is accepted when start_i rises while standby_ni is 1, no sequence is active and ch_mask_i is nonzero. busy_o is 1 on the next clock. ch_mask_i is captured only at acceptance, and later changes to it have no effect on the running sequence.
- R3: Synchronized conversion-clock falling edges detected within GUARD_CYC system cycles after acceptance are not counted.
- R4: Each selected channel takes exactly 16 counted falling edges. Channels are converted in ascending index order, where bit i of the mask selects channel i.
- R5: On the 14th counted edge of the first slot of a sequence, the read pointer moves to the lowest selected channel and first_o goes to 1.
- R6: On the 15th counted edge of every slot, eoc_no goes to 0 and sample_i[c*14 +: 14] of that slot's channel c is stored in register c.
- R7: On the 16th counted edge of every slot, eoc_no returns to 1.
- R8: On the 15th counted edge of the highest selected channel, busy_o goes to 0 in the same cycle that eoc_no falls.
- R9: A one-cycle rd_i pulse loads data_o with the register under the pointer on the next clock. The pointer then advances to the next selected channel in ascending order, wrapping from the highest to the lowest. Reading the lowest selected channel clears first_o. Before any sequence has been accepted, the pointer stays at channel 0.
- R10: A start_i rise is ignored in four cases: while busy_o is 1, while eoc_no is 0, when ch_mask_i is 0, or while standby_ni is 0.
- R11: While standby_ni is 0, falling edges are not counted and the sequence holds its state. Reads still work.
- R12: data_o changes only in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_clk_i | input | 1 | External conversion clock, asynchronous |
| start_i | input | 1 | Start request, acts on its rising edge |
| standby_ni | input | 1 | 0 puts the core in standby |
| ch_mask_i | input | NCH | Channel select mask, bit i selects channel i |
| sample_i | input | NCH*DW | Per-channel results from the analog stub |
| rd_i | input | 1 | Read strobe, one system cycle wide |
| busy_o | output | 1 | Sequence in progress |
| eoc_no | output | 1 | End of conversion, active low |
| first_o | output | 1 | Pointer addresses the first result of the sequence |
| data_o | output | DW | Read data bus |

## Verification
Falling edges are placed inside the guard window. A core that counted them would finish every slot early, and busy and EOC would move before the expected edge. A second start is issued in the gap between the last channel's 15th and 16th edges, where busy is already low. A core that looked only at busy would relaunch there. Mid-sequence changes to the channel mask and pauses in standby are mixed into random sequences. Using the live mask would store results in the wrong registers, and counting edges during standby would shift every status edge that follows. Reads wander through the sequence, and each sequence ends with a full pass around the pointer. A pointer that fails to wrap, skips unselected channels wrongly or misses the rewind shows up as wrong data or a wrong first flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned MAX_CH = 8;
  // counted-edge index inside a slot (0-based)
  localparam logic [3:0] EDGE_REWIND = 4'd13;
  localparam logic [3:0] EDGE_LATCH  = 4'd14;
  localparam logic [3:0] EDGE_LAST   = 4'd15;

  function automatic int unsigned ch_first(input logic [MAX_CH-1:0] m, input int unsigned n);
    ch_first = 0;
    for (int i = int'(n) - 1; i >= 0; i--) if (m[i]) ch_first = i;
  endfunction

  function automatic int unsigned ch_last(input logic [MAX_CH-1:0] m, input int unsigned n);
    ch_last = 0;
    for (int i = 0; i < int'(n); i++) if (m[i]) ch_last = i;
  endfunction

  function automatic int unsigned ch_next(input logic [MAX_CH-1:0] m, input int unsigned n,
                                          input int unsigned cur);
    ch_next = cur;
    for (int k = int'(n) - 1; k >= 1; k--) begin
      if (m[(cur + k) % n]) ch_next = (cur + k) % n;
    end
  endfunction
endpackage

// File: rtl/adc_seq_edge_sync.sv
module adc_seq_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[1:0], async_i};
  end

  assign fall_o = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned GUARD_CYC = 50,
  localparam int unsigned CHW      = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned GW       = $clog2(GUARD_CYC + 2)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fall_i,
  input  logic           start_i,
  input  logic           standby_ni,
  input  logic [NCH-1:0] ch_mask_i,
  output logic           busy_o,
  output logic           eoc_no,
  output logic [NCH-1:0] mask_o,
  output logic           latch_o,
  output logic [CHW-1:0] latch_ch_o,
  output logic           rewind_o
);
  logic           start_q, active_q, busy_q, eoc_nq, first_slot_q;
  logic [3:0]     edge_cnt_q;
  logic [CHW-1:0] cur_q, first_ch, next_ch;
  logic [NCH-1:0] mask_q;
  logic [GW-1:0]  guard_q;
  logic           accept, count_edge, is_last;

  assign accept     = start_i & ~start_q & standby_ni & ~active_q & (|ch_mask_i);
  assign count_edge = fall_i & active_q & standby_ni & (guard_q == '0);
  assign first_ch   = CHW'(ch_first(MAX_CH'(ch_mask_i), NCH));
  assign next_ch    = CHW'(ch_next(MAX_CH'(mask_q), NCH, int'(cur_q)));
  assign is_last    = (cur_q == CHW'(ch_last(MAX_CH'(mask_q), NCH)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q      <= 1'b0;
      active_q     <= 1'b0;
      busy_q       <= 1'b0;
      eoc_nq       <= 1'b1;
      first_slot_q <= 1'b0;
      edge_cnt_q   <= '0;
      cur_q        <= '0;
      mask_q       <= '0;
      guard_q      <= '0;
    end else begin
      start_q <= start_i;
      if (guard_q != '0) guard_q <= guard_q - 1'b1;
      if (accept) begin
        active_q     <= 1'b1;
        busy_q       <= 1'b1;
        first_slot_q <= 1'b1;
        mask_q       <= ch_mask_i;
        cur_q        <= first_ch;
        edge_cnt_q   <= '0;
        guard_q      <= GW'(GUARD_CYC);
      end else if (count_edge) begin
        edge_cnt_q <= edge_cnt_q + 1'b1;
        if (edge_cnt_q == EDGE_LATCH) begin
          eoc_nq <= 1'b0;
          if (is_last) busy_q <= 1'b0;
        end
        if (edge_cnt_q == EDGE_LAST) begin
          eoc_nq       <= 1'b1;
          edge_cnt_q   <= '0;
          first_slot_q <= 1'b0;
          if (is_last) active_q <= 1'b0;
          else         cur_q    <= next_ch;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign eoc_no     = eoc_nq;
  assign mask_o     = mask_q;
  assign latch_o    = count_edge & (edge_cnt_q == EDGE_LATCH);
  assign latch_ch_o = cur_q;
  assign rewind_o   = count_edge & first_slot_q & (edge_cnt_q == EDGE_REWIND);
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 14,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  logic [CHW-1:0]    latch_ch_i,
  input  logic              rewind_i,
  input  logic              rd_i,
  input  logic [NCH-1:0]    mask_i,
  input  logic [NCH*DW-1:0] sample_i,
  output logic [DW-1:0]     data_o,
  output logic              first_o
);
  logic [DW-1:0]  regs_q [NCH];
  logic [CHW-1:0] ptr_q, ptr_first, ptr_next;
  logic [DW-1:0]  data_q;
  logic           first_q;

  for (genvar c = 0; c < NCH; c++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[c] <= '0;
      else if (latch_i && latch_ch_i == CHW'(c))    regs_q[c] <= sample_i[c*DW +: DW];
    end
  end

  assign ptr_first = CHW'(ch_first(MAX_CH'(mask_i), NCH));
  assign ptr_next  = CHW'(ch_next(MAX_CH'(mask_i), NCH, int'(ptr_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      data_q  <= '0;
      first_q <= 1'b0;
    end else if (rewind_i) begin
      ptr_q   <= ptr_first;
      first_q <= 1'b1;
    end else if (rd_i) begin
      data_q <= regs_q[ptr_q];
      ptr_q  <= ptr_next;
      if (ptr_q == ptr_first) first_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign first_o = first_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int unsigned NCH       = 4,
  parameter int unsigned DW        = 14,
  parameter int unsigned GUARD_CYC = 50,
  localparam int unsigned CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_clk_i,
  input  logic              start_i,
  input  logic              standby_ni,
  input  logic [NCH-1:0]    ch_mask_i,
  input  logic [NCH*DW-1:0] sample_i,
  input  logic              rd_i,
  output logic              busy_o,
  output logic              eoc_no,
  output logic              first_o,
  output logic [DW-1:0]     data_o
);
  logic           fall;
  logic [NCH-1:0] mask;
  logic           latch, rewind;
  logic [CHW-1:0] latch_ch;

  adc_seq_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(conv_clk_i),
    .fall_o (fall)
  );

  adc_seq_ctrl #(.NCH(NCH), .GUARD_CYC(GUARD_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .start_i   (start_i),
    .standby_ni(standby_ni),
    .ch_mask_i (ch_mask_i),
    .busy_o    (busy_o),
    .eoc_no    (eoc_no),
    .mask_o    (mask),
    .latch_o   (latch),
    .latch_ch_o(latch_ch),
    .rewind_o  (rewind)
  );

  adc_seq_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_i   (latch),
    .latch_ch_i(latch_ch),
    .rewind_i  (rewind),
    .rd_i      (rd_i),
    .mask_i    (mask),
    .sample_i  (sample_i),
    .data_o    (data_o),
    .first_o   (first_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned DW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          standby_ni,
  input logic          rd_i,
  input logic          busy_o,
  input logic          eoc_no,
  input logic          first_o,
  input logic [DW-1:0] data_o
);
  // R2 / R10: busy only rises after a start request outside standby
  assert_busy_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i) && $past(standby_ni));

  assert_busy_with_eoc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $fell(eoc_no));

  assert_first_in_seq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(first_o) |-> busy_o && eoc_no);

  assert_first_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(first_o) |-> $past(rd_i));

  assert_data_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $past(rd_i));
endmodule

bind adc_seq_top adc_seq_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .standby_ni(standby_ni),
  .rd_i      (rd_i),
  .busy_o    (busy_o),
  .eoc_no    (eoc_no),
  .first_o   (first_o),
  .data_o    (data_o)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
  localparam int NCH = 4, DW = 14, GUARD = 50;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_ni, conv_clk, start_i, standby_ni, rd_i;
  logic [NCH-1:0]    ch_mask_i;
  logic [NCH*DW-1:0] sample_i;
  logic              busy_o, eoc_no, first_o;
  logic [DW-1:0]     data_o;

  adc_seq_top #(.NCH(NCH), .DW(DW), .GUARD_CYC(GUARD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .conv_clk_i(conv_clk), .start_i(start_i),
    .standby_ni(standby_ni), .ch_mask_i(ch_mask_i), .sample_i(sample_i), .rd_i(rd_i),
    .busy_o(busy_o), .eoc_no(eoc_no), .first_o(first_o), .data_o(data_o));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit            m_active, m_first_slot, exp_busy, exp_eoc, exp_first;
  int            m_cnt, m_cur, exp_ptr;
  logic [NCH-1:0] m_mask;
  logic [DW-1:0] samp [NCH];
  logic [DW-1:0] exp_regs [NCH];

  function automatic int f_first(logic [NCH-1:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return 0;
  endfunction
  function automatic int f_last(logic [NCH-1:0] m);
    int r = 0;
    for (int i = 0; i < NCH; i++) if (m[i]) r = i;
    return r;
  endfunction
  function automatic int f_next(logic [NCH-1:0] m, int cur);
    for (int k = 1; k < NCH; k++) if (m[(cur + k) % NCH]) return (cur + k) % NCH;
    return cur;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic check_status();
    chk("R8 busy", busy_o, exp_busy);
    chk("R7 eoc", eoc_no, exp_eoc);
    chk("R5 first", first_o, exp_first);
  endtask

  task automatic model_edge();
    m_cnt++;
    if (m_cnt == 14 && m_first_slot) begin exp_ptr = f_first(m_mask); exp_first = 1; end
    if (m_cnt == 15) begin  // R6
      exp_eoc = 0;
      exp_regs[m_cur] = samp[m_cur];
      if (m_cur == f_last(m_mask)) exp_busy = 0;
    end
    if (m_cnt == 16) begin  // R4
      exp_eoc = 1; m_cnt = 0; m_first_slot = 0;
      if (m_cur == f_last(m_mask)) m_active = 0;
      else m_cur = f_next(m_mask, m_cur);
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd_i = 1'b1;
    @(negedge clk) rd_i = 1'b0;
    chk("R9 data", data_o, exp_regs[exp_ptr]);
    if (exp_ptr == f_first(m_mask)) exp_first = 0;
    exp_ptr = f_next(m_mask, exp_ptr);
    chk("R9 first", first_o, exp_first);
  endtask

  task automatic conv_fall(bit counted);
    @(negedge clk) conv_clk = 1'b0;
    repeat (5) @(negedge clk);
    if (counted) model_edge();
    check_status();
    conv_clk = 1'b1;
  endtask

  task automatic conv_gap(bit rd);
    if (rd) do_read();
    repeat (2 + $urandom % 3) @(negedge clk);
  endtask

  task automatic try_start(logic [NCH-1:0] mask);
    ch_mask_i = mask;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (standby_ni && !m_active && mask != 0) begin
      m_active = 1; exp_busy = 1; m_mask = mask; m_cur = f_first(mask);
      m_cnt = 0; m_first_slot = 1;
    end
    chk("R10 busy after start", busy_o, exp_busy);
  endtask

  task automatic run_seq(logic [NCH-1:0] mask, int n_early, int rd_pct, bit extras);
    int n_edges = 0;
    for (int c = 0; c < NCH; c++) begin
      samp[c] = DW'($urandom);
      sample_i[c*DW +: DW] = samp[c];
    end
    try_start(mask);  // R2
    for (int i = 0; i < n_early; i++) begin  // R3: inside guard window
      conv_fall(0);
      repeat (3) @(negedge clk);
    end
    repeat (GUARD + 10) @(negedge clk);
    while (m_active && n_edges < 200) begin
      conv_fall(1);
      n_edges++;
      if (extras && n_edges == 20) begin
        ch_mask_i = ~mask;           // R2: live mask must not matter
        try_start(~mask);            // R10: start while busy
        standby_ni = 1'b0;           // R11
        conv_gap(0);
        for (int i = 0; i < 3; i++) begin
          conv_fall(0);
          chk("R11 busy held", busy_o, exp_busy);
          conv_gap(1);
        end
        standby_ni = 1'b1;
      end
      if (m_cnt == 15 && !exp_busy) try_start(mask);  // R10: start while eoc low
      conv_gap(($urandom % 100) < rd_pct);
    end
    chk("R4 sequence done", m_active, 0);
    ch_mask_i = mask;
    for (int i = 0; i < NCH; i++) do_read();
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 0; conv_clk = 1; start_i = 0; standby_ni = 1; rd_i = 0;
    ch_mask_i = '0; sample_i = '0;
    m_active = 0; m_first_slot = 0; exp_busy = 0; exp_eoc = 1; exp_first = 0;
    m_cnt = 0; m_cur = 0; exp_ptr = 0; m_mask = '0;
    for (int c = 0; c < NCH; c++) begin exp_regs[c] = '0; samp[c] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 eoc", eoc_no, 1);
    chk("R1 first", first_o, 0);
    chk("R1 data", data_o, 0);
    do_read();
    try_start('0);                   // R10: empty mask
    standby_ni = 0;
    try_start('1);                   // R10: standby
    do_read();
    standby_ni = 1;
    run_seq(4'b1111, 3, 30, 0);
    run_seq(4'b0101, 2, 30, 1);
    run_seq(4'b1000, 0, 50, 0);
    for (int s = 0; s < 8; s++) begin
      logic [NCH-1:0] m;
      m = NCH'($urandom);
      if (m == 0) m = 4'b0010;
      run_seq(m, $urandom % 4, 25, (s % 3) == 0);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule